// File: doc/BRIEF.md
# Continuous Read Mode Command Tracker

This block sits on the slave side of a serial flash interface that supports execute-in-place. It sees each chip-select-low transaction as a sequence of received bytes, with a strobe and a lane-width tag for each byte. Its job is to decide how a transaction starts. Normally the first byte is an opcode. When the previous transaction was a dual or quad I/O read whose mode byte asked to continue, the opcode is left out and the transaction starts directly in the address phase of that read.

Four read opcodes can enter this continuous mode. The dual I/O read `8'hBB` uses two lanes. The quad I/O reads `8'hEB`, `8'hE7` and `8'hE3` use four lanes. For these reads the tracker counts three address bytes and then takes the mode byte. Only bits 5:4 of the mode byte matter. When chip select rises after a complete mode byte, the tracker updates its continuous-mode flag and the implied opcode. The data path and the memory array sit outside this block.

Top module: `xip_cmd_tracker`

## Requirements
- R1: After reset `xip_active` is 0, `xip_cmd` is 8'h00, `cmd_valid` is 0, `addr_phase` is 0 and `phase_lanes` is 0 (single lane).
- R2: In normal mode the first byte of a transaction is the opcode. The cycle after it arrives, `cmd` equals that byte and `cmd_valid` is 1. For `8'hBB`, `8'hEB`, `8'hE7` and `8'hE3`, `addr_phase` is 1 and `phase_lanes` shows the command width (1 = dual for BB, 2 = quad for the others). It stays so for three address bytes, through the mode byte and in the data bytes after it.
- R3: Any other opcode gives `cmd_valid` 1 with `addr_phase` 0 and `phase_lanes` 0. The bytes that follow it, and the chip-select rise that ends it, leave `xip_active` and `xip_cmd` unchanged.
- R4: The fourth byte after the opcode of a continuable read is its mode byte. If mode bits [5:4] equal 2'b10, then the cycle after chip select rises `xip_active` is 1 and `xip_cmd` holds that read's opcode.
- R5: If mode bits [5:4] are any value other than 2'b10, then the cycle after chip select rises `xip_active` is 0 and the next transaction expects an opcode.
- R6: Mode bits [7:6] and [3:0] have no effect on the outcome.
- R7: With `xip_active` 1, the cycle after chip select falls shows `cmd` = `xip_cmd`, `cmd_valid` 1 and `addr_phase` 1 at that command's width, with no opcode byte. The first byte received is then taken as address.
- R8: `xip_active` and `xip_cmd` never change while chip select is low. A transaction that ends before its mode byte is complete leaves both unchanged.
- R9: A byte whose lane tag (0 single, 1 dual, 2 quad) differs from `phase_lanes` during the opcode, address or mode phase discards the transaction. From the next cycle `cmd_valid`, `addr_phase` and `phase_lanes` are 0, and the mode is unchanged at chip-select rise.
- R10: The cycle after chip select is seen high, `cmd_valid` and `addr_phase` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, sampled on clk |
| byte_vld | input | 1 | A received byte is present this cycle |
| byte_data | input | 8 | Received byte |
| byte_lanes | input | 2 | Lane width the byte was shifted in with: 0 single, 1 dual, 2 quad |
| cmd | output | 8 | Current command, received or implied |
| cmd_valid | output | 1 | `cmd` is known for the current transaction |
| addr_phase | output | 1 | Transaction is in its address phase |
| phase_lanes | output | 2 | Lane width expected for the current phase |
| xip_active | output | 1 | Continuous mode: next transaction omits the opcode |
| xip_cmd | output | 8 | Stored implied read opcode |

## Verification
The assertions assume three things. Chip select is seen high for at least one cycle between transactions. Reset is applied before the first transaction. The byte strobe is used only while chip select is low. The stimulus holds to this by construction. Each transaction lowers chip select for at least one cycle before any byte and raises it for two cycles afterwards. Strobes go out only between those two points. Inside those limits, the random mix varies the opcodes, the reserved mode bits, the number of bytes sent before chip select rises, and an occasional byte with the wrong lane tag.

// File: rtl/xip_trk_pkg.sv
package xip_trk_pkg;

    localparam int unsigned OPC_W     = 8;
    localparam int unsigned N_XIP     = 4;
    localparam int unsigned MODE_FLD  = 4;     // LSB of the two-bit continue field
    localparam logic [1:0]  MODE_KEEP = 2'b10;

    localparam logic [1:0] LN_SINGLE = 2'd0;
    localparam logic [1:0] LN_DUAL   = 2'd1;
    localparam logic [1:0] LN_QUAD   = 2'd2;

    // continuable read opcodes and their lane widths, entry i at [i*W +: W]
    localparam logic [N_XIP*OPC_W-1:0] XIP_OPC_TBL = {8'hE3, 8'hE7, 8'hEB, 8'hBB};
    localparam logic [N_XIP*2-1:0]     XIP_LN_TBL  = {LN_QUAD, LN_QUAD, LN_QUAD, LN_DUAL};

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_OPC   = 3'd1,
        PH_ADDR  = 3'd2,
        PH_MODE  = 3'd3,
        PH_DATA  = 3'd4,
        PH_OTHER = 3'd5,
        PH_ABORT = 3'd6
    } phase_e;

endpackage

// File: rtl/xip_cmd_class.sv
module xip_cmd_class
    import xip_trk_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output logic             capable,
    output logic [1:0]       lanes
);

    logic [N_XIP-1:0] hit;

    generate
        for (genvar i = 0; i < N_XIP; i++) begin : g_match
            assign hit[i] = (opc == XIP_OPC_TBL[i*OPC_W +: OPC_W]);
        end
    endgenerate

    always_comb begin
        capable = |hit;
        lanes   = LN_SINGLE;
        for (int i = 0; i < N_XIP; i++) begin
            if (hit[i]) lanes = XIP_LN_TBL[i*2 +: 2];
        end
    end

endmodule

// File: rtl/xip_mode_eval.sv
module xip_mode_eval
    import xip_trk_pkg::*;
(
    input  logic [1:0] fld,
    output logic       keep
);

    always_comb keep = (fld == MODE_KEEP);

endmodule

// File: rtl/xip_addr_count.sv
module xip_addr_count #(
    parameter int unsigned N_BYTES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int unsigned CW = (N_BYTES > 1) ? $clog2(N_BYTES + 1) : 1;

    logic [CW-1:0] cnt_q, cnt_d, base;

    always_comb begin
        base  = clr ? '0 : cnt_q;
        last  = (base == CW'(N_BYTES - 1));
        cnt_d = inc ? base + 1'b1 : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/xip_cmd_tracker.sv
module xip_cmd_tracker
    import xip_trk_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             byte_vld,
    input  logic [OPC_W-1:0] byte_data,
    input  logic [1:0]       byte_lanes,
    output logic [OPC_W-1:0] cmd,
    output logic             cmd_valid,
    output logic             addr_phase,
    output logic [1:0]       phase_lanes,
    output logic             xip_active,
    output logic [OPC_W-1:0] xip_cmd
);

    typedef struct packed {
        phase_e           phase;
        logic [OPC_W-1:0] cmd;
        logic             cmd_valid;
        logic             mode_done;
        logic             mode_hit;
        logic             xip;
        logic [OPC_W-1:0] xip_cmd;
    } trk_t;

    trk_t st_q, st_d;

    phase_e           ph_eff;
    logic [OPC_W-1:0] cmd_eff;
    logic             valid_eff;
    logic             opc_capable, cmd_capable, keep;
    logic [1:0]       opc_lanes, cmd_lanes, need_lanes;
    logic             cnt_clr, cnt_inc, addr_last;

    // A transaction starting in continuous mode enters the address phase at once
    always_comb begin
        if (st_q.phase == PH_IDLE) begin
            ph_eff    = st_q.xip ? PH_ADDR : PH_OPC;
            cmd_eff   = st_q.xip ? st_q.xip_cmd : st_q.cmd;
            valid_eff = st_q.xip;
        end else begin
            ph_eff    = st_q.phase;
            cmd_eff   = st_q.cmd;
            valid_eff = st_q.cmd_valid;
        end
    end

    xip_cmd_class u_opc_class (
        .opc     (byte_data),
        .capable (opc_capable),
        .lanes   (opc_lanes)
    );

    xip_cmd_class u_cur_class (
        .opc     (cmd_eff),
        .capable (cmd_capable),
        .lanes   (cmd_lanes)
    );

    xip_mode_eval u_mode (
        .fld  (byte_data[MODE_FLD +: 2]),
        .keep (keep)
    );

    always_comb begin
        unique case (ph_eff)
            PH_ADDR, PH_MODE, PH_DATA: need_lanes = cmd_capable ? cmd_lanes : LN_SINGLE;
            default:                   need_lanes = LN_SINGLE;
        endcase
    end

    assign cnt_clr = (st_q.phase == PH_IDLE);
    assign cnt_inc = !cs_n && byte_vld && (ph_eff == PH_ADDR) && (byte_lanes == need_lanes);

    xip_addr_count #(.N_BYTES(ADDR_BYTES)) u_acnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .last  (addr_last)
    );

    always_comb begin
        st_d = st_q;
        if (cs_n) begin
            st_d.phase     = PH_IDLE;
            st_d.cmd_valid = 1'b0;
            st_d.mode_done = 1'b0;
            st_d.mode_hit  = 1'b0;
            if (st_q.mode_done) begin
                st_d.xip = st_q.mode_hit;
                if (st_q.mode_hit) st_d.xip_cmd = st_q.cmd;
            end
        end else begin
            st_d.phase     = ph_eff;
            st_d.cmd       = cmd_eff;
            st_d.cmd_valid = valid_eff;
            if (byte_vld) begin
                unique case (ph_eff)
                    PH_OPC: begin
                        if (byte_lanes != LN_SINGLE) begin
                            st_d.phase     = PH_ABORT;
                            st_d.cmd_valid = 1'b0;
                        end else begin
                            st_d.cmd       = byte_data;
                            st_d.cmd_valid = 1'b1;
                            st_d.phase     = opc_capable ? PH_ADDR : PH_OTHER;
                        end
                    end
                    PH_ADDR: begin
                        if (byte_lanes != need_lanes) begin
                            st_d.phase     = PH_ABORT;
                            st_d.cmd_valid = 1'b0;
                        end else if (addr_last) begin
                            st_d.phase = PH_MODE;
                        end
                    end
                    PH_MODE: begin
                        if (byte_lanes != need_lanes) begin
                            st_d.phase     = PH_ABORT;
                            st_d.cmd_valid = 1'b0;
                        end else begin
                            st_d.mode_done = 1'b1;
                            st_d.mode_hit  = keep;
                            st_d.phase     = PH_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cmd: '0, cmd_valid: 1'b0, mode_done: 1'b0,
                      mode_hit: 1'b0, xip: 1'b0, xip_cmd: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd         = st_q.cmd;
    assign cmd_valid   = st_q.cmd_valid;
    assign addr_phase  = (st_q.phase == PH_ADDR);
    assign xip_active  = st_q.xip;
    assign xip_cmd     = st_q.xip_cmd;
    assign phase_lanes = (st_q.phase == PH_IDLE) ? LN_SINGLE : need_lanes;

endmodule

// File: rtl/xip_trk_chk.sv
module xip_trk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       byte_vld,
    input logic [1:0] byte_lanes,
    input logic [7:0] cmd,
    input logic       cmd_valid,
    input logic       addr_phase,
    input logic [1:0] phase_lanes,
    input logic       xip_active,
    input logic [7:0] xip_cmd
);

    a_r10_cs_high_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!cmd_valid && !addr_phase));

    a_r8_mode_frozen_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> ($stable(xip_active) && $stable(xip_cmd)));

    a_r7_implied_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(addr_phase) && !$past(byte_vld)) |-> (xip_active && cmd == xip_cmd));

    a_r2_addr_has_width: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |-> (cmd_valid && phase_lanes != 2'd0));

    a_r9_lane_mismatch_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && byte_vld && addr_phase && byte_lanes != phase_lanes)
            |=> (!addr_phase && !cmd_valid));

endmodule

bind xip_cmd_tracker xip_trk_chk u_xip_trk_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .byte_vld    (byte_vld),
    .byte_lanes  (byte_lanes),
    .cmd         (cmd),
    .cmd_valid   (cmd_valid),
    .addr_phase  (addr_phase),
    .phase_lanes (phase_lanes),
    .xip_active  (xip_active),
    .xip_cmd     (xip_cmd)
);

// File: tb/test_xip_cmd_tracker.sv
module test_xip_cmd_tracker;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic [1:0] byte_lanes;
    logic [7:0] cmd;
    logic       cmd_valid;
    logic       addr_phase;
    logic [1:0] phase_lanes;
    logic       xip_active;
    logic [7:0] xip_cmd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model of the mode state
    bit       m_xip;
    bit [7:0] m_xcmd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xip_cmd_tracker i_xip_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_vld(byte_vld),
        .byte_data(byte_data), .byte_lanes(byte_lanes), .cmd(cmd),
        .cmd_valid(cmd_valid), .addr_phase(addr_phase), .phase_lanes(phase_lanes),
        .xip_active(xip_active), .xip_cmd(xip_cmd)
    );

    function automatic bit is_cont(input bit [7:0] op);
        return op == 8'hBB || op == 8'hEB || op == 8'hE7 || op == 8'hE3;
    endfunction

    function automatic bit [1:0] width_of(input bit [7:0] op);
        if (op == 8'hBB) return 2'd1;
        if (is_cont(op)) return 2'd2;
        return 2'd0;
    endfunction

    // phases: 0 opcode, 1 address, 2 mode, 3 data, 4 other, 5 discarded
    function automatic bit [1:0] lanes_for(input int ph, input bit [7:0] cur);
        return (ph >= 1 && ph <= 3) ? width_of(cur) : 2'd0;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_phase(input string tag, input int ph, input bit [7:0] cur);
        bit v;
        v = (ph >= 1 && ph <= 4);
        chk(tag, "cmd_valid", cmd_valid, v);
        chk(tag, "addr_phase", addr_phase, ph == 1);
        chk(tag, "phase_lanes", phase_lanes, lanes_for(ph, cur));
        if (v) chk(tag, "cmd", cmd, cur);
    endtask

    // One transaction: nb bytes, opcode opc (if one is expected), mode byte md,
    // byte index wrong_at sent with a wrong lane tag.
    task automatic run_txn(input int nb, input bit [7:0] opc, input bit [7:0] md,
                           input int wrong_at, input bit gaps);
        int       ph, cnt;
        bit [7:0] cur, d;
        bit [1:0] ln;
        bit       mdone, mhit;
        string    tag;
        mdone = 0; mhit = 0; cnt = 0;
        cs_n = 1'b0;
        tick();
        if (m_xip) begin ph = 1; cur = m_xcmd; tag = "R7"; end
        else begin ph = 0; cur = cmd; tag = "R2"; end
        chk_phase(tag, ph, cur);
        for (int i = 0; i < nb; i++) begin
            ln = lanes_for(ph, cur);
            if (i == wrong_at) ln = (ln == 2'd0) ? 2'd2 : 2'd0;
            d = (ph == 0) ? opc : (ph == 2) ? md : 8'($urandom);
            byte_vld = 1'b1; byte_data = d; byte_lanes = ln;
            case (ph)
                0: if (ln != 0) ph = 5;
                   else begin cur = d; ph = is_cont(d) ? 1 : 4; end
                1: if (ln != width_of(cur)) ph = 5;
                   else begin cnt++; if (cnt == 3) ph = 2; end
                2: if (ln != width_of(cur)) ph = 5;
                   else begin mdone = 1; mhit = (d[5:4] == 2'b10); ph = 3; end
                default: ;
            endcase
            tick();
            byte_vld = 1'b0;
            tag = (ph == 5) ? "R9" : (ph == 4) ? "R3" : "R2";
            chk_phase(tag, ph, cur);
            if (gaps && ($urandom % 3 == 0)) begin
                tick();
                chk_phase(tag, ph, cur);
            end
        end
        chk("R8", "xip_active before rise", xip_active, m_xip);
        cs_n = 1'b1;
        tick();
        if (mdone) begin
            m_xip = mhit;
            if (mhit) m_xcmd = cur;
            tag = mhit ? "R4" : "R5";
        end else begin
            tag = (ph == 4) ? "R3" : "R8";
        end
        chk(tag, "xip_active", xip_active, m_xip);
        chk(tag, "xip_cmd", xip_cmd, m_xcmd);
        chk("R10", "cmd_valid after rise", cmd_valid, 0);
        chk("R10", "addr_phase after rise", addr_phase, 0);
        tick();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        bit [7:0] op, md;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cs_n = 1'b1; byte_vld = 1'b0; byte_data = '0; byte_lanes = '0;
        m_xip = 0; m_xcmd = 8'h00;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1", "xip_active", xip_active, 0);
        chk("R1", "xip_cmd", xip_cmd, 0);
        chk("R1", "cmd_valid", cmd_valid, 0);
        chk("R1", "addr_phase", addr_phase, 0);
        chk("R1", "phase_lanes", phase_lanes, 0);

        // R3: plain read opcode, no address phase, mode untouched
        run_txn(5, 8'h03, 8'h20, 99, 0);
        chk("R3", "stays normal", xip_active, 0);
        // R4: quad read with continue field 2'b10
        run_txn(6, 8'hEB, 8'h20, 99, 0);
        chk("R4", "entered", xip_active, 1);
        // R7 + R6: implied opcode, reserved bits all ones around 2'b10
        run_txn(5, 8'h00, 8'hEF, 99, 0);
        chk("R6", "reserved ones ignored", xip_active, 1);
        // R8: chip select rises after two address bytes
        run_txn(2, 8'h00, 8'h00, 99, 0);
        chk("R8", "abort keeps mode", xip_active, 1);
        chk("R8", "abort keeps cmd", xip_cmd, 8'hEB);
        // R5: field 2'b11 leaves continuous mode
        run_txn(4, 8'h00, 8'h30, 99, 0);
        chk("R5", "exit on 11", xip_active, 0);
        // R6: dual read, reserved bits mixed, field 10
        run_txn(5, 8'hBB, 8'hA5, 99, 0);
        chk("R6", "dual entered", xip_active, 1);
        chk("R6", "dual cmd", xip_cmd, 8'hBB);
        // R9: wrong lane tag in address phase of implied transaction
        run_txn(5, 8'h00, 8'h00, 1, 0);
        chk("R9", "discard keeps mode", xip_active, 1);
        // R5: field 00 exits
        run_txn(4, 8'h00, 8'h00, 99, 0);
        chk("R5", "exit on 00", xip_active, 0);
        // R5: field 01 on octal word read does not enter
        run_txn(5, 8'hE3, 8'h10, 99, 0);
        chk("R5", "no entry on 01", xip_active, 0);
        // R9: wrong lane tag on the opcode
        run_txn(3, 8'hE7, 8'h20, 0, 0);
        chk("R9", "opcode discard", xip_active, 0);

        for (int n = 0; n < 400; n++) begin
            case ($urandom % 5)
                0: op = 8'hBB;
                1: op = 8'hEB;
                2: op = 8'hE7;
                3: op = 8'hE3;
                default: op = 8'($urandom);
            endcase
            md = 8'($urandom);
            if ($urandom % 2 == 0) md[5:4] = 2'b10;
            run_txn($urandom % 8, op, md, ($urandom % 8 == 0) ? int'($urandom % 6) : 99, 1);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule